// File: doc/BRIEF.md
# Banked Vector Register Index Sequencer

This block drives the register-file addressing for a short-vector floating-point operation. A request presents a destination index, two source indices, a precision select and a three-bit length field. The block then emits one index triple per cycle. Each index walks through the bank it started in, and when it steps past the top of that bank it returns to the bottom of the same bank. In single precision a bank holds eight registers. In double precision a bank holds four.

The banks holding the registers decide how the request runs. A destination in the lowest bank makes the operation scalar, whatever the length field says. A destination outside that bank makes it a vector operation. A vector operation with a source in the lowest bank is mixed: that source stays fixed while the other indices advance. The block computes no arithmetic and stores no register contents. It only sequences addresses and reports the operation class.

Top module: `vreg_seq`

## Requirements
- R1: After reset, busy_o, valid_o, last_o and illegal_o are all 0.
- R2: A legal start_i pulse while idle makes valid_o and busy_o 1 on the next cycle. That first triple equals the given dst_i, srca_i and srcb_i.
- R3: In single precision (dbl_i=0), each later element keeps index bits [4:3]. Bits [2:0] advance by one modulo 8, so offset 7 returns to offset 0 of the same bank.
- R4: In double precision (dbl_i=1), each later element keeps index bits [4:2]. Bits [1:0] advance by one modulo 4.
- R5: A non-scalar operation emits len_i+1 elements. last_o is 1 only on the final element, and busy_o and valid_o fall in the following cycle.
- R6: A destination in bank 0 (index below 8 for single, below 4 for double) gives kind_o=2'b00 and exactly one element, whatever len_i holds.
- R7: A destination outside bank 0 with no source in bank 0 gives kind_o=2'b01, and all three indices advance.
- R8: A destination outside bank 0 with a source in bank 0 gives kind_o=2'b10. Every such source index holds its start value for all elements.
- R9: A double-precision start with len_i above 3 raises illegal_o for one cycle, one cycle after the start. No operation begins.
- R10: A start_i pulse while busy_o is 1 is ignored. The running sequence continues unchanged and ends after its own length.
- R11: With DBL_REGS=16, a double-precision start with any index of 16 or more is flagged illegal, in the same way as R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request pulse |
| dbl_i | input | 1 | 1 selects double precision |
| len_i | input | 3 | Element count minus one |
| dst_i | input | 5 | Destination start index |
| srca_i | input | 5 | First source start index |
| srcb_i | input | 5 | Second source start index |
| busy_o | output | 1 | Sequence in progress |
| valid_o | output | 1 | Index triple valid this cycle |
| last_o | output | 1 | Final element of the sequence |
| illegal_o | output | 1 | Rejected-request pulse |
| kind_o | output | 2 | 00 scalar, 01 vector, 10 mixed |
| dst_o | output | 5 | Destination index of this element |
| srca_o | output | 5 | First source index of this element |
| srcb_o | output | 5 | Second source index of this element |

## Verification
The first element and an illegal_o pulse both appear one clock edge after the start_i edge. Each later element appears one edge after the element before it, and busy_o falls one edge after the element flagged last. The bench drives inputs on falling edges and samples every output on the next falling edge after each rising edge. It compares these values with a model that counts elements forward from the start. A second instance, configured with 16 double registers and sharing the same inputs, is sampled on the same cycle as the main instance to check its illegal pulse.

// File: rtl/vseq_pkg.sv
package vseq_pkg;
  localparam int IDX_W = 5;
  localparam int LEN_W = 3;
  localparam int NLANE = 3;

  typedef enum logic [1:0] {
    VK_SCALAR = 2'b00,
    VK_VECTOR = 2'b01,
    VK_MIXED  = 2'b10
  } vkind_e;

  // lowest bank: 8 singles or 4 doubles
  function automatic logic in_bank0(input logic dbl, input logic [IDX_W-1:0] idx);
    return dbl ? (idx[IDX_W-1:2] == '0) : (idx[IDX_W-1:3] == '0);
  endfunction

  // advance the in-bank offset, keep the bank bits
  function automatic logic [IDX_W-1:0] step_idx(input logic dbl, input logic [IDX_W-1:0] idx);
    logic [IDX_W-1:0] r;
    r = idx;
    if (dbl) r[1:0] = idx[1:0] + 2'd1;
    else     r[2:0] = idx[2:0] + 3'd1;
    return r;
  endfunction
endpackage

// File: rtl/vseq_class.sv
module vseq_class
  import vseq_pkg::*;
#(
  parameter int DBL_REGS = 32
) (
  input  logic             dbl,
  input  logic [LEN_W-1:0] len,
  input  logic [IDX_W-1:0] dst,
  input  logic [IDX_W-1:0] srca,
  input  logic [IDX_W-1:0] srcb,
  output vkind_e           kind,
  output logic             hold_a,
  output logic             hold_b,
  output logic             bad,
  output logic [LEN_W-1:0] cnt_m1
);
  localparam int DBL_MAX_M1 = 3;

  logic dst0, a0, b0, range_bad;

  always_comb begin
    dst0      = in_bank0(dbl, dst);
    a0        = in_bank0(dbl, srca);
    b0        = in_bank0(dbl, srcb);
    range_bad = (int'(dst) >= DBL_REGS) || (int'(srca) >= DBL_REGS) ||
                (int'(srcb) >= DBL_REGS);
    bad       = dbl && ((int'(len) > DBL_MAX_M1) || range_bad);
    if (dst0)          kind = VK_SCALAR;
    else if (a0 || b0) kind = VK_MIXED;
    else               kind = VK_VECTOR;
    hold_a = !dst0 && a0;
    hold_b = !dst0 && b0;
    cnt_m1 = dst0 ? '0 : len;
  end
endmodule

// File: rtl/vseq_ctrl.sv
module vseq_ctrl
  import vseq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [LEN_W-1:0] cnt_m1,
  output logic             busy,
  output logic             last,
  output logic             adv
);
  logic [LEN_W-1:0] cnt_q, lim_q;

  assign last = busy && (cnt_q == lim_q);
  assign adv  = busy && !last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      cnt_q <= '0;
      lim_q <= '0;
    end else if (go) begin
      busy  <= 1'b1;
      cnt_q <= '0;
      lim_q <= cnt_m1;
    end else if (last) begin
      busy  <= 1'b0;
    end else if (adv) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/vseq_lane.sv
module vseq_lane
  import vseq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             adv,
  input  logic             dbl,
  input  logic [IDX_W-1:0] seed,
  input  logic             hold_in,
  output logic [IDX_W-1:0] idx
);
  logic hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx    <= '0;
      hold_q <= 1'b0;
    end else if (load) begin
      idx    <= seed;
      hold_q <= hold_in;
    end else if (adv && !hold_q) begin
      idx    <= step_idx(dbl, idx);
    end
  end
endmodule

// File: rtl/vreg_seq.sv
module vreg_seq
  import vseq_pkg::*;
#(
  parameter int DBL_REGS = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       dbl_i,
  input  logic [2:0] len_i,
  input  logic [4:0] dst_i,
  input  logic [4:0] srca_i,
  input  logic [4:0] srcb_i,
  output logic       busy_o,
  output logic       valid_o,
  output logic       last_o,
  output logic       illegal_o,
  output logic [1:0] kind_o,
  output logic [4:0] dst_o,
  output logic [4:0] srca_o,
  output logic [4:0] srcb_o
);
  vkind_e           kind_c, kind_q;
  logic             hold_a, hold_b, bad;
  logic [LEN_W-1:0] cnt_m1;
  logic             accept, reject, adv, busy, last;
  logic             dbl_q, illegal_q;

  logic [IDX_W-1:0] seed_v [NLANE];
  logic             hold_v [NLANE];
  logic [IDX_W-1:0] idx_v  [NLANE];

  vseq_class #(.DBL_REGS(DBL_REGS)) u_class (
    .dbl(dbl_i), .len(len_i), .dst(dst_i), .srca(srca_i), .srcb(srcb_i),
    .kind(kind_c), .hold_a(hold_a), .hold_b(hold_b), .bad(bad), .cnt_m1(cnt_m1)
  );

  assign accept = start_i && !busy && !bad;
  assign reject = start_i && !busy && bad;

  vseq_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .go(accept), .cnt_m1(cnt_m1),
    .busy(busy), .last(last), .adv(adv)
  );

  assign seed_v[0] = dst_i;
  assign seed_v[1] = srca_i;
  assign seed_v[2] = srcb_i;
  assign hold_v[0] = 1'b0;
  assign hold_v[1] = hold_a;
  assign hold_v[2] = hold_b;

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    vseq_lane u_lane (
      .clk(clk), .rst_n(rst_n), .load(accept), .adv(adv), .dbl(dbl_q),
      .seed(seed_v[g]), .hold_in(hold_v[g]), .idx(idx_v[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q    <= VK_SCALAR;
      dbl_q     <= 1'b0;
      illegal_q <= 1'b0;
    end else begin
      illegal_q <= reject;
      if (accept) begin
        kind_q <= kind_c;
        dbl_q  <= dbl_i;
      end
    end
  end

  assign busy_o    = busy;
  assign valid_o   = busy;
  assign last_o    = last;
  assign illegal_o = illegal_q;
  assign kind_o    = kind_q;
  assign dst_o     = idx_v[0];
  assign srca_o    = idx_v[1];
  assign srcb_o    = idx_v[2];
endmodule

// File: rtl/vreg_seq_chk.sv
module vreg_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy_o,
  input logic       valid_o,
  input logic       last_o,
  input logic       illegal_o,
  input logic [1:0] kind_o,
  input logic       dbl,
  input logic [4:0] dst_o,
  input logic [4:0] srca_o
);
  logic step_seen;
  assign step_seen = valid_o && !last_o;

  AST_SCALAR_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && kind_o == 2'b00) |-> last_o); // R6
  AST_SINGLE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (step_seen && !dbl) |=> (dst_o[4:3] == $past(dst_o[4:3]) && dst_o[2:0] == $past(dst_o[2:0]) + 3'd1)); // R3
  AST_DOUBLE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (step_seen && dbl) |=> (dst_o[4:2] == $past(dst_o[4:2]) && dst_o[1:0] == $past(dst_o[1:0]) + 2'd1)); // R4
  AST_MIXED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (step_seen && kind_o == 2'b10 && (dbl ? srca_o < 5'd4 : srca_o < 5'd8)) |=> $stable(srca_o)); // R8
  AST_REJECT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_o |-> !busy_o); // R9
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    step_seen |=> valid_o); // R10
  AST_END_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    last_o |=> !valid_o); // R5
endmodule

bind vreg_seq vreg_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy_o(busy_o), .valid_o(valid_o), .last_o(last_o),
  .illegal_o(illegal_o), .kind_o(kind_o), .dbl(dbl_q), .dst_o(dst_o), .srca_o(srca_o)
);

// File: tb/vreg_seq_tb.sv
`timescale 1ns/1ps
module vreg_seq_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic start_i = 1'b0, start16 = 1'b0, dbl_i = 1'b0;
  logic [2:0] len_i = '0;
  logic [4:0] dst_i = '0, srca_i = '0, srcb_i = '0;
  logic busy_o, valid_o, last_o, illegal_o;
  logic [1:0] kind_o;
  logic [4:0] dst_o, srca_o, srcb_o;
  logic b16, v16, l16, ill16_o;
  logic [1:0] k16;
  logic [4:0] d16, a16, s16;
  int nchk = 0, nfail = 0;

  always #2 clk = ~clk;

  vreg_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .dbl_i(dbl_i), .len_i(len_i),
    .dst_i(dst_i), .srca_i(srca_i), .srcb_i(srcb_i), .busy_o(busy_o), .valid_o(valid_o),
    .last_o(last_o), .illegal_o(illegal_o), .kind_o(kind_o), .dst_o(dst_o),
    .srca_o(srca_o), .srcb_o(srcb_o)
  );

  vreg_seq #(.DBL_REGS(16)) u_d16 (
    .clk(clk), .rst_n(rst_n), .start_i(start16), .dbl_i(dbl_i), .len_i(len_i),
    .dst_i(dst_i), .srca_i(srca_i), .srcb_i(srcb_i), .busy_o(b16), .valid_o(v16),
    .last_o(l16), .illegal_o(ill16_o), .kind_o(k16), .dst_o(d16),
    .srca_o(a16), .srcb_o(s16)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit low_bank(input bit d, input int idx);
    return d ? (idx < 4) : (idx < 8);
  endfunction

  function automatic int nxt(input bit d, input int idx);
    int sz = d ? 4 : 8;
    return (idx / sz) * sz + ((idx % sz) + 1) % sz;
  endfunction

  task automatic run_op(input bit d, input int l, input int dd, input int a, input int b,
                        input bit inj);
    bit ill, ill16, ha, hb, dz;
    int n, ed, ea, eb, ek;
    string rk, ri;
    ill   = d && l > 3;
    ill16 = d && (l > 3 || dd >= 16 || a >= 16 || b >= 16);
    @(negedge clk);
    dbl_i = d; len_i = 3'(l); dst_i = 5'(dd); srca_i = 5'(a); srcb_i = 5'(b);
    start_i = 1'b1; start16 = 1'b1;
    @(negedge clk);
    start_i = 1'b0; start16 = 1'b0;
    chk(ill16_o == ill16, "R11", int'(ill16_o), int'(ill16));
    chk(illegal_o == ill, "R9", int'(illegal_o), int'(ill));
    if (ill) begin
      chk(busy_o == 1'b0, "R9", int'(busy_o), 0);
      @(negedge clk);
      chk(illegal_o == 1'b0, "R9", int'(illegal_o), 0);
      return;
    end
    dz = low_bank(d, dd);
    ha = !dz && low_bank(d, a);
    hb = !dz && low_bank(d, b);
    ek = dz ? 0 : (ha || hb) ? 2 : 1;
    rk = (ek == 0) ? "R6" : (ek == 1) ? "R7" : "R8";
    n  = dz ? 1 : l + 1;
    ed = dd; ea = a; eb = b;
    for (int k = 0; k < n; k++) begin
      ri = (k == 0) ? "R2" : (d ? "R4" : "R3");
      if (inj && k > 0) ri = "R10";
      chk(valid_o == 1'b1, ri, int'(valid_o), 1);
      chk(last_o == (k == n - 1), "R5", int'(last_o), int'(k == n - 1));
      chk(int'(kind_o) == ek, rk, int'(kind_o), ek);
      chk(int'(dst_o) == ed, ri, int'(dst_o), ed);
      chk(int'(srca_o) == ea, ha ? "R8" : ri, int'(srca_o), ea);
      chk(int'(srcb_o) == eb, hb ? "R8" : ri, int'(srcb_o), eb);
      ed = nxt(d, ed);
      if (!ha) ea = nxt(d, ea);
      if (!hb) eb = nxt(d, eb);
      if (inj && k == 0 && n > 1) begin
        start_i = 1'b1; dbl_i = ~d; len_i = 3'($urandom_range(0, 7));
        dst_i = 5'($urandom_range(0, 31)); srca_i = 5'($urandom_range(0, 31));
        srcb_i = 5'($urandom_range(0, 31));
      end else start_i = 1'b0;
      @(negedge clk);
    end
    start_i = 1'b0;
    chk(busy_o == 1'b0, "R5", int'(busy_o), 0);
    chk(valid_o == 1'b0, inj ? "R10" : "R5", int'(valid_o), 0);
  endtask

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'd5150);
    #1;
    chk(busy_o == 0 && valid_o == 0 && last_o == 0 && illegal_o == 0, "R1",
        int'({busy_o, valid_o, last_o, illegal_o}), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk(busy_o == 0 && valid_o == 0, "R1", int'({busy_o, valid_o}), 0);
    // directed corners
    run_op(0, 7, 3, 12, 20, 0);   // R6 scalar, length ignored
    run_op(0, 7, 14, 22, 30, 0);  // R3 single wrap mid-bank
    run_op(1, 3, 29, 18, 7, 0);   // R4 double wrap
    run_op(0, 4, 9, 2, 17, 0);    // R8 mixed single
    run_op(1, 2, 6, 1, 3, 0);     // R8 mixed double, both held
    run_op(1, 5, 8, 12, 16, 0);   // R9 illegal length
    run_op(1, 1, 20, 8, 9, 0);    // R11 index beyond 16 doubles
    run_op(0, 5, 13, 21, 27, 1);  // R10 start while busy
    run_op(1, 0, 4, 8, 12, 0);    // R7 single element vector
    for (int i = 0; i < 300; i++) begin
      bit d;
      int l;
      d = 1'($urandom_range(0, 1));
      l = (i % 10 == 0) ? $urandom_range(0, 7) : (d ? $urandom_range(0, 3) : $urandom_range(0, 7));
      run_op(d, l, $urandom_range(0, 31), $urandom_range(0, 31), $urandom_range(0, 31),
             1'($urandom_range(0, 3) == 0));
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nchk++;
    nfail++;
    $display("FAIL R5 watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
    $finish;
  end
endmodule